// File: doc/BRIEF.md
# Serial-In Shift Register with Latched Parallel Outputs

This block takes a serial bit stream on a shift clock and moves it through a chain of eight stages. On a second, independent latch clock, the whole chain is copied into a storage register. The storage register drives eight parallel output lines that can be switched off as a group. The last shift stage also leaves the block as a serial cascade output. Wiring that output to the serial input of another copy builds a wider register, for example sixteen bits from two copies that share their clocks.

The shift stages have their own active-low clear, which acts at once and does not touch the storage register. The parallel outputs come out in two forms. The first is a data bus with a per-bit drive qualifier, which any fabric can route. The second is an optional set of real tri-state pins, chosen by a parameter. The output enable has no effect on the cascade output, which is never high impedance.

Top module: `sreg_latched_out`

## Requirements
- R1: On each rising shift_clk edge while shift_rst_n is high, stage 0 takes ser_in and each stage k takes the previous value of stage k-1. For a group of W bits sent most significant bit first, bit j of the group therefore ends up in stage j.
- R2: ser_out always equals stage W-1, so chained copies form one longer register. The first bit sent leaves on ser_out after W shift edges.
- R3: A low level on shift_rst_n clears every shift stage at once, with no clock edge needed, so ser_out reads 0. The storage register and par_data keep their values.
- R4: On each rising latch_clk edge, the storage register loads all W shift stages.
- R5: While out_en_n is high, par_oe is all zeros, par_data is all zeros, and (in tri-state mode) par_pin is high impedance on every bit. While out_en_n is low, par_oe is all ones and both par_data and par_pin equal the storage register.
- R6: Changing out_en_n leaves ser_out unchanged.
- R7: Without a rising latch_clk edge the storage register holds its value, however many shift edges occur.
- R8: When a shift_clk edge and a latch_clk edge arrive together, the storage register loads the stage contents from before that shift.
- R9: When shift_rst_n rises together with a shift_clk edge, that edge shifts ser_in into an all-zero chain, leaving only stage 0 possibly set.
- R10: The storage register starts at all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Shift clock, rising edge active |
| shift_rst_n | input | 1 | Active-low asynchronous clear of the shift stages only |
| latch_clk | input | 1 | Storage load clock, rising edge active |
| out_en_n | input | 1 | Active-low enable of the parallel outputs |
| par_data | output | W | Storage contents, forced to zero while disabled |
| par_oe | output | W | Per-bit drive qualifier for par_data |
| par_pin | output | W | Parallel pins, high impedance while disabled in tri-state mode |
| ser_out | output | 1 | Cascade output, the last shift stage |

## Verification
Two pairs of events can fall in the same instant. In the first, a shift edge and a latch edge arrive together. The bench raises both clocks in the same time step after loading a known word. It then expects the storage register to show the word from before the shift, and a second latch alone to show the word after it. In the second, the clear is released and a shift edge arrives at the same moment. The bench drives both changes in one step on a chain full of ones and expects only stage 0 to hold the new bit.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int unsigned SREG_W_DEF = 8;

    // How the parallel outputs reach the pins.
    typedef enum logic {
        PIN_TRISTATE  = 1'b0,
        PIN_QUALIFIED = 1'b1
    } pin_mode_e;

    // One parallel output line: drive qualifier plus level.
    typedef struct packed {
        logic drive;
        logic level;
    } pin_t;

    function automatic pin_t make_pin(input logic en, input logic lvl);
        pin_t p;
        p.drive = en;
        p.level = en & lvl;
        return p;
    endfunction

endpackage

// File: rtl/sreg_shift_chain.sv
module sreg_shift_chain #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         din,
    output logic [W-1:0] stages,
    output logic         dout
);
    localparam int unsigned LAST = W - 1;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            stages <= '0;
        end else begin
            stages <= {stages[LAST-1:0], din};
        end
    end

    assign dout = stages[LAST];
endmodule

// File: rtl/sreg_store.sv
module sreg_store #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] hold_q = '0;

    always_ff @(posedge clk) begin
        hold_q <= d;
    end

    assign q = hold_q;
endmodule

// File: rtl/sreg_oe_gate.sv
module sreg_oe_gate
    import sreg_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         oe_n,
    input  logic [W-1:0] value,
    output pin_t [W-1:0] pins
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign pins[i] = make_pin(!oe_n, value[i]);
    end
endmodule

// File: rtl/sreg_latched_out.sv
module sreg_latched_out
    import sreg_pkg::*;
#(
    parameter int unsigned W    = SREG_W_DEF,
    parameter pin_mode_e   MODE = PIN_TRISTATE
) (
    input  logic         ser_in,
    input  logic         shift_clk,
    input  logic         shift_rst_n,
    input  logic         latch_clk,
    input  logic         out_en_n,
    output logic [W-1:0] par_data,
    output logic [W-1:0] par_oe,
    output logic [W-1:0] par_pin,
    output logic         ser_out
);
    logic [W-1:0] shift_q;
    logic [W-1:0] store_q;
    pin_t [W-1:0] pins;

    sreg_shift_chain #(.W(W)) u_chain (
        .clk    (shift_clk),
        .clr_n  (shift_rst_n),
        .din    (ser_in),
        .stages (shift_q),
        .dout   (ser_out)
    );

    sreg_store #(.W(W)) u_store (
        .clk (latch_clk),
        .d   (shift_q),
        .q   (store_q)
    );

    sreg_oe_gate #(.W(W)) u_gate (
        .oe_n  (out_en_n),
        .value (store_q),
        .pins  (pins)
    );

    for (genvar i = 0; i < W; i++) begin : g_out
        assign par_data[i] = pins[i].level;
        assign par_oe[i]   = pins[i].drive;
        if (MODE == PIN_TRISTATE) begin : g_tri
            assign par_pin[i] = pins[i].drive ? pins[i].level : 1'bz;
        end else begin : g_qual
            assign par_pin[i] = pins[i].level;
        end
    end
endmodule

// File: rtl/sreg_latched_out_chk.sv
module sreg_latched_out_chk #(
    parameter int unsigned W = 8
) (
    input logic         shift_clk,
    input logic         shift_rst_n,
    input logic         latch_clk,
    input logic         ser_in,
    input logic         out_en_n,
    input logic         ser_out,
    input logic [W-1:0] shift_q,
    input logic [W-1:0] store_q,
    input logic [W-1:0] par_oe
);
    logic         s_armed;
    logic         l_armed = 1'b0;
    logic [W-1:0] snap    = '0;

    always_ff @(posedge shift_clk or negedge shift_rst_n) begin
        if (!shift_rst_n) s_armed <= 1'b0;
        else              s_armed <= 1'b1;
    end

    always_ff @(posedge latch_clk) begin
        l_armed <= 1'b1;
        snap    <= shift_q;
    end

    // R1: stage 0 holds the serial input of the previous shift edge
    assert_first_stage_R1: assert property (@(posedge shift_clk) disable iff (!shift_rst_n)
        s_armed |-> (shift_q[0] == $past(ser_in)));

    // R2: cascade output follows the next-to-last stage one edge later
    assert_cascade_R2: assert property (@(posedge shift_clk) disable iff (!shift_rst_n)
        s_armed |-> (ser_out == $past(shift_q[W-2])));

    // R3: while clear is held, the cascade output reads zero
    assert_clear_R3: assert property (@(posedge shift_clk)
        !shift_rst_n |-> (ser_out == 1'b0 && shift_q == '0));

    // R4, R7, R8: storage equals the stages seen at the previous latch edge
    assert_latch_hold_R4: assert property (@(posedge latch_clk)
        l_armed |-> (store_q == snap));

    // R5: disabled outputs carry no drive qualifier
    assert_no_drive_R5: assert property (@(posedge latch_clk)
        out_en_n |-> (par_oe == '0));
endmodule

bind sreg_latched_out sreg_latched_out_chk #(.W(W)) u_chk (
    .shift_clk   (shift_clk),
    .shift_rst_n (shift_rst_n),
    .latch_clk   (latch_clk),
    .ser_in      (ser_in),
    .out_en_n    (out_en_n),
    .ser_out     (ser_out),
    .shift_q     (shift_q),
    .store_q     (store_q),
    .par_oe      (par_oe)
);

// File: tb/sreg_latched_out_tb.sv
module sreg_latched_out_tb;
    import sreg_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       ser_in;
    logic       sclk;
    logic       lclk;
    logic       rst_n;
    logic       oe_n;
    logic [7:0] lo_data, lo_oe, lo_pin, hi_data, hi_oe, hi_pin;
    logic       lo_ser_out, hi_ser_out;

    int n_checks = 0;
    int n_err    = 0;

    sreg_latched_out #(.W(8), .MODE(PIN_TRISTATE)) u_dut (
        .ser_in(ser_in), .shift_clk(sclk), .shift_rst_n(rst_n), .latch_clk(lclk),
        .out_en_n(oe_n), .par_data(lo_data), .par_oe(lo_oe), .par_pin(lo_pin),
        .ser_out(lo_ser_out)
    );

    sreg_latched_out #(.W(8), .MODE(PIN_TRISTATE)) u_dut_hi (
        .ser_in(lo_ser_out), .shift_clk(sclk), .shift_rst_n(rst_n), .latch_clk(lclk),
        .out_en_n(oe_n), .par_data(hi_data), .par_oe(hi_oe), .par_pin(hi_pin),
        .ser_out(hi_ser_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        ser_in = b;
        #2 sclk = 1'b1;
        #4 sclk = 1'b0;
        #2;
    endtask

    task automatic latch();
        #2 lclk = 1'b1;
        #4 lclk = 1'b0;
        #2;
    endtask

    task automatic shift_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #10 rst_n = 1'b1;
        #4;
        check("R3 cascade after clear", {15'd0, lo_ser_out}, 16'h0000);
        check("R10 storage starts at zero", {hi_data, lo_data}, 16'h0000);
    endtask

    task automatic t_chain(input logic [15:0] w, input logic [15:0] prev);
        shift_word(w);
        check("R2 cascade of chain is first bit", {15'd0, hi_ser_out}, {15'd0, w[15]});
        check("R7 storage unchanged before latch", {hi_data, lo_data}, prev);
        latch();
        check("R1 R4 word order after latch", {hi_data, lo_data}, w);
        check("R5 pins follow storage", {hi_pin, lo_pin}, w);
        shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
        check("R7 storage holds over shifts", {hi_data, lo_data}, w);
    endtask

    task automatic t_oe();
        logic [15:0] stored;
        logic        so_lo, so_hi;
        stored = {hi_data, lo_data};
        so_lo  = lo_ser_out;
        so_hi  = hi_ser_out;
        oe_n = 1'b1;
        #2;
        check("R5 qualifier off", {hi_oe, lo_oe}, 16'h0000);
        check("R5 data zero while off", {hi_data, lo_data}, 16'h0000);
        check("R5 pins high impedance", {hi_pin, lo_pin}, 16'hzzzz);
        check("R6 cascade ignores enable", {14'd0, so_hi, so_lo}, {14'd0, hi_ser_out, lo_ser_out});
        oe_n = 1'b0;
        #2;
        check("R5 qualifier on", {hi_oe, lo_oe}, 16'hffff);
        check("R5 pins restored", {hi_pin, lo_pin}, stored);
        check("R6 cascade after re-enable", {14'd0, so_hi, so_lo}, {14'd0, hi_ser_out, lo_ser_out});
    endtask

    task automatic t_clear_mid();
        shift_word(16'hffff);
        check("R2 cascade reads last stage", {15'd0, lo_ser_out}, 16'h0001);
        latch();
        rst_n = 1'b0;
        #4;
        check("R3 cascade cleared at once", {14'd0, hi_ser_out, lo_ser_out}, 16'h0000);
        check("R3 storage kept during clear", {hi_data, lo_data}, 16'hffff);
        rst_n = 1'b1;
        #4;
        latch();
        check("R3 stages were cleared", {hi_data, lo_data}, 16'h0000);
    endtask

    task automatic t_coincide();
        shift_word(16'h1234);
        ser_in = 1'b1;
        #2;
        sclk = 1'b1;
        lclk = 1'b1;
        #4;
        sclk = 1'b0;
        lclk = 1'b0;
        #2;
        check("R8 coincident latch takes old stages", {hi_data, lo_data}, 16'h1234);
        latch();
        check("R8 shift landed after coincident edge", {hi_data, lo_data}, 16'h2469);
    endtask

    task automatic t_release();
        shift_word(16'hffff);
        rst_n = 1'b0;
        #4;
        ser_in = 1'b1;
        #2;
        rst_n = 1'b1;
        sclk  = 1'b1;
        #4 sclk = 1'b0;
        #2;
        latch();
        check("R9 release edge shifts into zeros", {hi_data, lo_data}, 16'h0001);
    endtask

    initial begin
        ser_in = 1'b0;
        sclk   = 1'b0;
        lclk   = 1'b0;
        oe_n   = 1'b0;
        rst_n  = 1'b0;
        t_reset();
        t_chain(16'ha5c3, 16'h0000);
        t_chain(16'h3c96, 16'ha5c3);
        t_oe();
        t_clear_mid();
        t_coincide();
        t_release();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule